// File: doc/BRIEF.md
# Converter Interrupt Raw/Mask/Status-Clear Unit

This block keeps the interrupt flags of a converter that runs four sample sequencers. Each sequencer raises three kinds of event: a sequence finished, its DMA transfer finished, and a digital-comparator match. The sequence and DMA events each get one sticky raw flag per sequencer. All comparator matches share a single sticky raw flag. A mask register enables each source per sequencer. A combined status/clear register returns raw AND mask on read, and clears raw flags when software writes 1 to them.

The block drives one level-sensitive interrupt line to an external interrupt controller. The line stays high while any masked status bit is set. Software reaches the block through a simple register port: an address, a one-cycle write strobe and a one-cycle read strobe. Read data is returned in the same cycle as the read strobe. Event pulses arrive from the sequencer logic, one cycle wide each.

Top module: `adc_irq_unit`

## Requirements
- R1: After synchronous reset, all raw flags and mask bits are 0, every register reads 0, and `irq_o` is 0.
- R2: An event pulse sets its raw flag, and the flag stays set until it is cleared. The raw register at offset 0x4 shows the sequence flags in bits 3:0 (sequencer n at bit n), the DMA flags in bits 11:8 (sequencer n at bit 8+n), and the shared comparator flag in bit 16.
- R3: The status register at offset 0xC reads, for each sequence bit (3:0) and each DMA bit (11:8), the raw flag AND the mask bit at the same position.
- R4: Status bit 16+n reads the shared comparator flag AND mask bit 16+n. The mask register at offset 0x8 uses the same layout as the status register.
- R5: Writing 1 to status bit n (3:0) or to status bit 8+n (11:8) clears that raw flag. Writing 0 to those bits changes nothing.
- R6: A write-1 clear through the status register works even when the matching mask bit is 0.
- R7: Writing 1 to any of status bits 19:16 clears the shared comparator flag, whatever the mask holds.
- R8: When an event and a write-1 clear hit the same raw flag in the same cycle, the flag ends up set.
- R9: `irq_o` is 1 exactly when at least one status bit is 1.
- R10: Writes to the raw register are ignored. Reserved bits (all bits except 19:16, 11:8 and 3:0) read 0 in every register and are ignored on write.
- R11: The mask register is read/write. A write loads bits 19:16, 11:8 and 3:0, and these bits read back unchanged.
- R12: A read of an unmapped offset returns 0, and a write to an unmapped offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (4) | Byte offset of the register |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd`, 0 otherwise |
| seq_done_evt | input | 4 | Sequence-complete pulses, one bit per sequencer |
| dma_done_evt | input | 4 | DMA-complete pulses, one bit per sequencer |
| cmp_match_evt | input | 1 | Comparator match pulse feeding the shared flag |
| irq_o | output | 1 | Level interrupt to the interrupt controller |

## Verification
The flags are first set from one event source at a time. Each is read through the raw view and through the status view under full, empty and partial masks, so that a wrong mask position or a wrong field offset shows up. Clears are then tried in several ways:
- with the mask off and on;
- with a zero write;
- through a single comparator status bit whose own mask bit is off, which tests that the comparator flag is shared;
- in the same cycle as a new event on the same flag.

A final set of writes goes to the raw register, to reserved bits and to an unmapped offset. The state is then read back to show that none of these writes had an effect.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

    localparam int NUM_SEQ = 4;
    localparam int REG_W   = 32;
    localparam int SEQ_LSB = 0;
    localparam int DMA_LSB = 8;
    localparam int CMP_LSB = 16;
    localparam int RAW_W   = 2 * NUM_SEQ + 1;

    localparam int RAW_OFS  = 4;
    localparam int MASK_OFS = 8;
    localparam int STAT_OFS = 12;

    typedef logic [NUM_SEQ-1:0] seq_vec_t;

    typedef struct packed {
        logic     cmp;
        seq_vec_t dma;
        seq_vec_t seq;
    } raw_flags_t;

    typedef struct packed {
        seq_vec_t cmp;
        seq_vec_t dma;
        seq_vec_t seq;
    } mask_bits_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RAW,
        SEL_MASK,
        SEL_STAT
    } reg_sel_e;

    function automatic logic [REG_W-1:0] pack_raw(raw_flags_t r);
        logic [REG_W-1:0] v;
        v = '0;
        v[SEQ_LSB +: NUM_SEQ] = r.seq;
        v[DMA_LSB +: NUM_SEQ] = r.dma;
        v[CMP_LSB]            = r.cmp;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_mask(mask_bits_t m);
        logic [REG_W-1:0] v;
        v = '0;
        v[SEQ_LSB +: NUM_SEQ] = m.seq;
        v[DMA_LSB +: NUM_SEQ] = m.dma;
        v[CMP_LSB +: NUM_SEQ] = m.cmp;
        return v;
    endfunction

    function automatic mask_bits_t unpack_mask(logic [REG_W-1:0] v);
        mask_bits_t m;
        m.seq = v[SEQ_LSB +: NUM_SEQ];
        m.dma = v[DMA_LSB +: NUM_SEQ];
        m.cmp = v[CMP_LSB +: NUM_SEQ];
        return m;
    endfunction

    function automatic mask_bits_t masked_status(raw_flags_t r, mask_bits_t m);
        mask_bits_t s;
        s.seq = r.seq & m.seq;
        s.dma = r.dma & m.dma;
        s.cmp = {NUM_SEQ{r.cmp}} & m.cmp;
        return s;
    endfunction

endpackage

// File: rtl/adc_irq_raw.sv
module adc_irq_raw
    import adc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [RAW_W-1:0] set_i,
    input  logic [RAW_W-1:0] clr_i,
    output logic [RAW_W-1:0] raw_o
);

    logic [RAW_W-1:0] raw_q;

    // A set in the same cycle as a clear wins, so that no event is lost.
    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= (raw_q & ~clr_i) | set_i;
    end

    assign raw_o = raw_q;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|(set_i & clr_i)) |=> ((raw_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

    a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((raw_q & $past(clr_i & ~set_i)) == '0));

    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        ((set_i == '0) && (clr_i == '0)) |=> $stable(raw_q));

endmodule

// File: rtl/adc_irq_mask.sv
module adc_irq_mask
    import adc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  mask_bits_t wr_data,
    output mask_bits_t mask_o
);

    mask_bits_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)        mask_q <= '0;
        else if (wr_en) mask_q <= wr_data;
    end

    assign mask_o = mask_q;

    a_r11_mask_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mask_q == $past(wr_data)));

    a_r11_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/adc_irq_regif.sv
module adc_irq_regif
    import adc_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_W-1:0]  wdata,
    input  raw_flags_t        raw,
    input  mask_bits_t        mask,
    input  mask_bits_t        status,
    output logic              mask_wr,
    output mask_bits_t        mask_wdata,
    output raw_flags_t        clr,
    output logic [REG_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(RAW_OFS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    reg_sel_e sel;

    always_comb begin
        case (addr)
            A_RAW:   sel = SEL_RAW;
            A_MASK:  sel = SEL_MASK;
            A_STAT:  sel = SEL_STAT;
            default: sel = SEL_NONE;
        endcase
    end

    assign mask_wr    = wr && (sel == SEL_MASK);
    assign mask_wdata = unpack_mask(wdata);

    // Write-1-to-clear; any comparator status bit clears the shared flag.
    always_comb begin
        clr = '0;
        if (wr && (sel == SEL_STAT)) begin
            clr.seq = wdata[SEQ_LSB +: NUM_SEQ];
            clr.dma = wdata[DMA_LSB +: NUM_SEQ];
            clr.cmp = |wdata[CMP_LSB +: NUM_SEQ];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_RAW:  rdata = pack_raw(raw);
                SEL_MASK: rdata = pack_mask(mask);
                SEL_STAT: rdata = pack_mask(status);
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/adc_irq_unit.sv
module adc_irq_unit
    import adc_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_SEQ-1:0] seq_done_evt,
    input  logic [NUM_SEQ-1:0] dma_done_evt,
    input  logic              cmp_match_evt,
    output logic              irq_o
);

    localparam logic [REG_W-1:0] VALID_BITS =
        pack_mask('{cmp: '1, dma: '1, seq: '1});

    raw_flags_t set_v, clr_v, raw_v;
    mask_bits_t mask_v, mask_wdata, status_v;
    logic       mask_wr;

    assign set_v.seq = seq_done_evt;
    assign set_v.dma = dma_done_evt;
    assign set_v.cmp = cmp_match_evt;

    adc_irq_raw u_raw (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v),
        .clr_i (clr_v),
        .raw_o (raw_v)
    );

    adc_irq_mask u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mask_wr),
        .wr_data (mask_wdata),
        .mask_o  (mask_v)
    );

    assign status_v = masked_status(raw_v, mask_v);

    adc_irq_regif #(.ADDR_W(ADDR_W)) u_regif (
        .addr       (reg_addr),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .wdata      (reg_wdata),
        .raw        (raw_v),
        .mask       (mask_v),
        .status     (status_v),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .clr        (clr_v),
        .rdata      (reg_rdata)
    );

    assign irq_o = |status_v;

    // R9: the line may only be high with some raw flag and some enable set.
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((raw_v != '0) && (mask_v != '0)));

    // R4: any comparator status bit implies the shared raw flag.
    a_r4_cmp_shared: assert property (@(posedge clk) disable iff (rst)
        (|status_v.cmp) |-> raw_v.cmp);

    // R10: reserved positions never read as 1.
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> ((reg_rdata & ~VALID_BITS) == '0));

endmodule

// File: tb/adc_irq_unit_tb_top.sv
module adc_irq_unit_tb_top;
    import adc_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  seq_done_evt = '0;
    logic [3:0]  dma_done_evt = '0;
    logic        cmp_match_evt = 1'b0;
    logic        irq_o;
    logic        chk_irq = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    adc_irq_unit dut_i (
        .clk           (clk),
        .rst           (rst),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .seq_done_evt  (seq_done_evt),
        .dma_done_evt  (dma_done_evt),
        .cmp_match_evt (cmp_match_evt),
        .irq_o         (irq_o)
    );

    // Monitor: compares in mid-cycle, while the strobe is held.
    always @(negedge clk) begin
        if (reg_rd || chk_irq) begin
            item_t it;
            logic [31:0] act;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty (R1) actual=item expected=none");
            end else begin
                it = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(input logic [3:0] a, input logic w, input logic r,
                        input logic [31:0] d, input logic [3:0] s,
                        input logic [3:0] dm, input logic c, input logic ci);
        @(posedge clk);
        #1;
        reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d;
        seq_done_evt = s; dma_done_evt = dm; cmp_match_evt = c; chk_irq = ci;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(a, 1'b1, 1'b0, d, 4'h0, 4'h0, 1'b0, 1'b0);
    endtask

    task automatic pulse(input logic [3:0] s, input logic [3:0] dm, input logic c);
        step(4'h0, 1'b0, 1'b0, '0, s, dm, c, 1'b0);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        step(a, 1'b0, 1'b1, '0, 4'h0, 4'h0, 1'b0, 1'b0);
    endtask

    task automatic irq_chk(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        step(4'h0, 1'b0, 1'b0, '0, 4'h0, 4'h0, 1'b0, 1'b1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        rd_chk(4'h4, 32'h0, "R1 raw after reset");
        rd_chk(4'h8, 32'h0, "R1 mask after reset");
        rd_chk(4'hC, 32'h0, "R1 status after reset");
        irq_chk(1'b0, "R1 irq after reset");

        wr(4'h8, 32'hFFFF_FFFF);
        rd_chk(4'h8, 32'h000F_0F0F, "R11 mask readback, R10 reserved");
        wr(4'h4, 32'hFFFF_FFFF);
        rd_chk(4'h4, 32'h0, "R10 raw write ignored");

        pulse(4'b0101, 4'h0, 1'b0);
        rd_chk(4'h4, 32'h0000_0005, "R2 sequence flags set");
        rd_chk(4'hC, 32'h0000_0005, "R3 status full mask");
        irq_chk(1'b1, "R9 irq high");

        wr(4'h8, 32'h0);
        rd_chk(4'hC, 32'h0, "R3 status empty mask");
        irq_chk(1'b0, "R9 irq low when masked");
        rd_chk(4'h4, 32'h0000_0005, "R2 flags stay set");

        wr(4'hC, 32'h1);
        rd_chk(4'h4, 32'h0000_0004, "R6 clear with mask off");
        wr(4'hC, 32'h0);
        rd_chk(4'h4, 32'h0000_0004, "R5 zero write no effect");
        wr(4'hC, 32'h4);
        rd_chk(4'h4, 32'h0, "R5 clear bit 2");

        wr(4'h8, 32'h0000_0800);
        pulse(4'h0, 4'b1000, 1'b0);
        rd_chk(4'hC, 32'h0000_0800, "R3 dma status bit 11");
        irq_chk(1'b1, "R9 irq from dma");

        pulse(4'h0, 4'h0, 1'b1);
        wr(4'h8, 32'h000A_0800);
        rd_chk(4'h4, 32'h0001_0800, "R2 shared cmp flag bit 16");
        rd_chk(4'hC, 32'h000A_0800, "R4 cmp status per mask");

        wr(4'hC, 32'h0004_0000);
        rd_chk(4'h4, 32'h0000_0800, "R7 cmp cleared via masked-off bit");
        rd_chk(4'hC, 32'h0000_0800, "R7 cmp status gone");

        step(4'hC, 1'b1, 1'b0, 32'h2, 4'b0010, 4'h0, 1'b0, 1'b0);
        rd_chk(4'h4, 32'h0000_0802, "R8 set wins over clear");

        wr(4'hC, 32'h0000_0802);
        rd_chk(4'h4, 32'h0, "R5 clear dma and seq");
        irq_chk(1'b0, "R9 irq low after clear");

        rd_chk(4'h0, 32'h0, "R12 unmapped read");
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk(4'h8, 32'h000A_0800, "R12 unmapped write no effect");

        pulse(4'b0001, 4'h0, 1'b0);
        wr(4'hC, 32'hFFF0_F0F0);
        rd_chk(4'h4, 32'h0000_0001, "R10 reserved clear bits ignored");

        step(4'h0, 1'b0, 1'b0, '0, 4'h0, 4'h0, 1'b0, 1'b0);
        step(4'h0, 1'b0, 1'b0, '0, 4'h0, 4'h0, 1'b0, 1'b0);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover (R1) actual=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule